// File: doc/BRIEF.md
# Stereo I2S Programmable Sample Delay

This block sits in a stereo I2S path and holds the audio back by a whole number of sample periods, so that sound can be brought into step with a slower video path. Each incoming left/right word pair is written into a circular frame memory. The pair that was received a selected number of frames earlier is read back and sent out as an I2S stream on the same bit clock and word clock. Because the output keeps the input format and clocks, two instances can be placed in series and their delays add.

A five-bit select input sets the delay in steps of 2^S frames plus 2^S − 1 frames, where S is `STEP_LOG2`. With S = 8 the range runs from 255 to 8191 frames and needs an 8192-frame memory. The default of 6 keeps the memory at 2048 frames. All logic runs on the bit clock and has no separate system clock. After reset, and after any change of delay, the output stays silent until the memory holds enough fresh frames, so stale contents never reach the listener.

Top module: `i2s_lipsync_delay`

## Requirements
- R1: Serial data and word clock are sampled on the rising bit-clock edge. Word clock low marks the left slot and high marks the right slot. Each word starts MSB first, one bit clock after the word-clock change. The output follows the same framing and the same clocks.
- R2: With select value s, the delay is D = 2^S·s + 2^S − 1 frames. Frames are counted from the first left slot that begins after reset, as frame 0. Once valid, output frame n carries input frame n − D.
- R3: Both channels use the same delay, so the left and right words of one input frame come out together in one output frame.
- R4: Slots of 32, 24 and 16 bit clocks are accepted and carry words of up to 24 bits. Bits after the 24th in a slot are ignored, and the output drives 0 in those positions.
- R5: In a slot shorter than 24 bit clocks, only the received bits are stored. The missing LSBs are stored and sent as 0.
- R6: The output is 0 while reset is held. After reset, output frames 0 to D − 1 are all-zero on both channels, where D comes from the select value held at the first left slot.
- R7: Suppose the select input changes during frame m, at least two bit clocks before that frame ends, and then stays at s'. The new delay D' then takes effect at frame m + 2. Output frames m + 2 to m + 1 + D' are silent, and frame m + 2 + D' onward carries input frame n − D'. The in-force delay changes only at a left-slot start.
- R8: A select change that does not stay steady across a whole frame is ignored. The delay is unchanged and the output is not muted.
- R9: The output changes only on the falling bit-clock edge, so it is stable across every rising edge.
- R10: The frame memory holds 2^(S+5) frames and is addressed modulo its depth. The largest delay, 2^(S+5) − 1 frames, stays correct after the write pointer has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock; the only clock of the block |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrclk_i | input | 1 | Word clock: low selects the left slot, high the right slot |
| sdata_i | input | 1 | Serial audio input, MSB first |
| dsel_i | input | 5 | Delay select value s |
| sdata_o | output | 1 | Delayed serial audio output, changing on the falling bit-clock edge |

## Verification
The bench targets the exact frame where data first appears after reset and after a delay change. A design with an off-by-one read offset or fill count would show up there as one frame of stale or missing audio. Short 16-clock slots and 32-clock slots with ones driven past bit 24 expose a deserialiser that keeps old LSBs or lets padding leak into the stored word. A brief glitch on the select input must leave the stream unmuted, which catches a design that adopts an unsettled value. The largest delay is run past several pointer wraps, which catches address arithmetic that fails at the memory edge.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int SEL_W = 5;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic bnd;  // right->left change: frame boundary, left slot starts
    logic mid;  // left->right change: right slot starts
  } slot_ev_t;
endpackage

// File: rtl/lsd_rx.sv
module lsd_rx
  import lsd_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  output slot_ev_t          ev_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  logic              lr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] acc_q, acc_nx, left_q;
  logic              chg;

  assign chg = lrclk_i ^ lr_q;

  // bit sampled on the changing edge still belongs to the previous slot
  always_comb begin
    acc_nx = acc_q;
    if (int'(idx_q) < WORD_W) acc_nx[WORD_W-1-int'(idx_q)] = sdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q   <= 1'b1;
      idx_q  <= '0;
      acc_q  <= '0;
      left_q <= '0;
    end else begin
      lr_q <= lrclk_i;
      if (chg) begin
        idx_q <= '0;
        acc_q <= '0;
        if (lrclk_i) left_q <= acc_nx;
      end else begin
        acc_q <= acc_nx;
        if (idx_q != '1) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign ev_o.bnd = chg & ~lrclk_i;
  assign ev_o.mid = chg & lrclk_i;
  assign left_o   = left_q;
  assign right_o  = acc_nx;
endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
#(
  parameter int STEP_LOG2 = 6,
  parameter int ADDR_W    = STEP_LOG2 + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  dsel_i,
  input  slot_ev_t          ev_i,
  output logic              armed_o,
  output logic              adopt_o,
  output logic              valid_o,
  output logic [SEL_W-1:0]  act_o,
  output logic [ADDR_W:0]   fill_o,
  output logic [ADDR_W-1:0] offset_o
);
  logic [SEL_W-1:0] dsel_q, cand_q, act_q;
  logic             seen_q, armed_q;
  logic [ADDR_W:0]  fill_q, span, dly_m1;

  // read offset = D - 1 (one frame of capture latency)
  assign span   = (ADDR_W+1)'(act_q) + (ADDR_W+1)'(1);
  assign dly_m1 = (span << STEP_LOG2) - (ADDR_W+1)'(2);

  assign adopt_o = ev_i.bnd && armed_q && seen_q && (dsel_q == cand_q)
                   && (cand_q != act_q);
  assign valid_o = ev_i.bnd && armed_q && !adopt_o && (fill_q >= dly_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsel_q  <= '0;
      cand_q  <= '0;
      act_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
      fill_q  <= '0;
    end else begin
      dsel_q <= dsel_i;
      if (dsel_q != cand_q) begin
        cand_q <= dsel_q;
        seen_q <= 1'b0;
      end else if (ev_i.bnd) begin
        seen_q <= 1'b1;
      end
      if (ev_i.bnd && !armed_q) act_q <= dsel_q;
      else if (adopt_o)         act_q <= cand_q;
      if (ev_i.bnd) begin
        armed_q <= 1'b1;
        if (!armed_q || adopt_o)  fill_q <= '0;
        else if (fill_q != '1)    fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign armed_o  = armed_q;
  assign act_o    = act_q;
  assign fill_o   = fill_q;
  assign offset_o = dly_m1[ADDR_W-1:0];
endmodule

// File: rtl/lsd_store.sv
module lsd_store
  import lsd_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  slot_ev_t            ev_i,
  input  logic                armed_i,
  input  logic [ADDR_W-1:0]   offset_i,
  input  logic [2*WORD_W-1:0] wdata_i,
  output logic [2*WORD_W-1:0] rdata_o,
  output logic [ADDR_W-1:0]   wptr_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [2*WORD_W-1:0] mem [DEPTH];
  logic [2*WORD_W-1:0] rd_q;
  logic [ADDR_W-1:0]   wptr_q;
  logic                wr_en;

  assign wr_en = ev_i.bnd & armed_i;

  // write at frame boundary, prefetch next output frame at mid-frame
  always_ff @(posedge clk_i) begin
    if (wr_en)     mem[wptr_q] <= wdata_i;
    if (ev_i.mid)  rd_q <= mem[wptr_q - offset_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wptr_q <= '0;
    else if (wr_en) wptr_q <= wptr_q + 1'b1;
  end

  assign rdata_o = rd_q;
  assign wptr_o  = wptr_q;
endmodule

// File: rtl/lsd_tx.sv
module lsd_tx
  import lsd_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  slot_ev_t            ev_i,
  input  logic                valid_i,
  input  logic [2*WORD_W-1:0] frame_i,
  output logic                bit_o
);
  logic [WORD_W-1:0] word_q, rsv_q, load_l, load_r;
  logic [IDX_W-1:0]  idx_q;
  logic              bit_q;

  assign load_l = valid_i ? frame_i[2*WORD_W-1:WORD_W] : '0;
  assign load_r = valid_i ? frame_i[WORD_W-1:0]        : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      rsv_q  <= '0;
      idx_q  <= '0;
      bit_q  <= 1'b0;
    end else if (ev_i.bnd) begin
      word_q <= load_l;
      rsv_q  <= load_r;
      bit_q  <= load_l[WORD_W-1];
      idx_q  <= IDX_W'(1);
    end else if (ev_i.mid) begin
      word_q <= rsv_q;
      bit_q  <= rsv_q[WORD_W-1];
      idx_q  <= IDX_W'(1);
    end else begin
      bit_q <= (int'(idx_q) < WORD_W) ? word_q[WORD_W-1-int'(idx_q)] : 1'b0;
      if (idx_q != '1) idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/i2s_lipsync_delay.sv
module i2s_lipsync_delay
  import lsd_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int STEP_LOG2 = 6
) (
  input  logic             bclk_i,
  input  logic             rst_ni,
  input  logic             lrclk_i,
  input  logic             sdata_i,
  input  logic [SEL_W-1:0] dsel_i,
  output logic             sdata_o
);
  localparam int ADDR_W = STEP_LOG2 + SEL_W;

  slot_ev_t            ev;
  logic                bnd_w, armed, adopt, valid, tx_bit;
  logic [WORD_W-1:0]   left_w, right_w;
  logic [SEL_W-1:0]    act_sel;
  logic [ADDR_W:0]     fill;
  logic [ADDR_W-1:0]   offset, wptr;
  logic [2*WORD_W-1:0] rd_frame;

  assign bnd_w = ev.bnd;

  lsd_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i(bclk_i), .rst_ni(rst_ni), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
    .ev_o(ev), .left_o(left_w), .right_o(right_w)
  );

  lsd_ctrl #(.STEP_LOG2(STEP_LOG2), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i(bclk_i), .rst_ni(rst_ni), .dsel_i(dsel_i), .ev_i(ev),
    .armed_o(armed), .adopt_o(adopt), .valid_o(valid), .act_o(act_sel),
    .fill_o(fill), .offset_o(offset)
  );

  lsd_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i(bclk_i), .rst_ni(rst_ni), .ev_i(ev), .armed_i(armed),
    .offset_i(offset), .wdata_i({left_w, right_w}), .rdata_o(rd_frame),
    .wptr_o(wptr)
  );

  lsd_tx #(.WORD_W(WORD_W)) u_tx (
    .clk_i(bclk_i), .rst_ni(rst_ni), .ev_i(ev), .valid_i(valid),
    .frame_i(rd_frame), .bit_o(tx_bit)
  );

  // launch on the falling edge so the next stage samples mid-bit
  always_ff @(negedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) sdata_o <= 1'b0;
    else         sdata_o <= tx_bit;
  end
endmodule

// File: rtl/lsd_sva.sv
module lsd_sva #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bnd_i,
  input logic              armed_i,
  input logic              adopt_i,
  input logic [4:0]        act_i,
  input logic [ADDR_W:0]   fill_i,
  input logic [ADDR_W-1:0] offset_i,
  input logic [ADDR_W-1:0] wptr_i,
  input logic              tx_bit_i
);
  AST_MUTE_UNTIL_FILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_i && armed_i && (fill_i < {1'b0, offset_i})) |=> !tx_bit_i); // R6

  AST_NO_FILL_BEFORE_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> (fill_i == '0)); // R6

  AST_ADOPT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adopt_i |=> !tx_bit_i); // R7

  AST_SEL_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_i) |-> $past(bnd_i)); // R7

  AST_WPTR_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wptr_i) |-> $past(bnd_i)); // R10
endmodule

bind i2s_lipsync_delay lsd_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i(bclk_i), .rst_ni(rst_ni), .bnd_i(bnd_w), .armed_i(armed),
  .adopt_i(adopt), .act_i(act_sel), .fill_i(fill), .offset_i(offset),
  .wptr_i(wptr), .tx_bit_i(tx_bit)
);

// File: tb/sim_i2s_lipsync_delay.sv
`timescale 1ns/1ps
module sim_i2s_lipsync_delay;
  localparam int STEP = 2;
  localparam int NF   = 512;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lrclk = 1'b1;
  logic       sdata = 1'b0;
  logic [4:0] dsel = '0;
  logic       sdata_o;

  int total = 0, bad = 0, r9_bad = 0, pad_bad = 0;
  int bps = 32, fcnt = 0;
  int chg_frame = -1, glitch = 0;
  logic [4:0] chg_val = '0, restore_val = '0;
  logic [23:0] in_l [NF];
  logic [23:0] in_r [NF];
  logic [23:0] out_l [NF];
  logic [23:0] out_r [NF];

  always #10 clk = ~clk;

  i2s_lipsync_delay #(.WORD_W(24), .STEP_LOG2(STEP)) u0 (
    .bclk_i(clk), .rst_ni(rst_ni), .lrclk_i(lrclk), .sdata_i(sdata),
    .dsel_i(dsel), .sdata_o(sdata_o)
  );

  function automatic int dly(input int s);
    return (s << STEP) + (1 << STEP) - 1;
  endfunction

  function automatic logic [23:0] msk(input logic [23:0] w);
    if (bps >= 24) return w;
    return w & ~((24'd1 << (24 - bps)) - 24'd1);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [23:0] act,
                     input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive_slot(input logic lr, input logic [23:0] w,
                            output logic [23:0] got);
    logic s1;
    got = '0;
    for (int k = 0; k < bps; k++) begin
      @(negedge clk);
      if (chg_frame == fcnt && lr == 1'b0 && k == 8)  dsel = chg_val;
      if (chg_frame == fcnt && lr == 1'b0 && k == 12 && glitch != 0) dsel = restore_val;
      sdata = (k < 24) ? w[23-k] : 1'b1;  // ones past bit 24 must be ignored
      lrclk = (k == bps - 1) ? ~lr : lr;
      @(posedge clk);
      s1 = sdata_o;
      if (k < 24) got[23-k] = s1;
      else if (s1 !== 1'b0) pad_bad++;
      #5;
      if (sdata_o !== s1) r9_bad++;
    end
  endtask

  task automatic run_frame(input logic [23:0] l, input logic [23:0] r);
    logic [23:0] gl, gr;
    drive_slot(1'b0, l, gl);
    drive_slot(1'b1, r, gr);
    in_l[fcnt] = msk(l);
    in_r[fcnt] = msk(r);
    out_l[fcnt] = gl;
    out_r[fcnt] = gr;
    fcnt++;
  endtask

  task automatic run_frames(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++)
      run_frame({seed, 1'b0, 15'(fcnt * 7 + 1)}, {~seed, 1'b1, 15'(fcnt * 13 + 5)});
  endtask

  task automatic do_reset(input logic [4:0] s, input int nbps);
    @(negedge clk);
    rst_ni = 1'b0; lrclk = 1'b1; sdata = 1'b0; dsel = s; bps = nbps;
    chg_frame = -1; glitch = 0;
    repeat (3) @(negedge clk);
    chk(sdata_o === 1'b0, "R6 reset output", 24'(sdata_o), 24'h0);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lrclk = (k == 3) ? 1'b0 : 1'b1;
      sdata = 1'b0;
    end
    fcnt = 0;
  endtask

  task automatic check_span(input int lo, input int hi, input int d, input int vfirst,
                            input string req);
    logic [23:0] el, er;
    for (int n = lo; n <= hi; n++) begin
      el = (n >= vfirst) ? in_l[n-d] : 24'h0;
      er = (n >= vfirst) ? in_r[n-d] : 24'h0;
      chk(out_l[n] === el, req, out_l[n], el);
      chk(out_r[n] === er, req, out_r[n], er);
    end
  endtask

  // R1 R2 R3 R6: 64 bclk per frame, smallest delay
  task automatic t_basic();
    do_reset(5'd0, 32);
    run_frames(14, 8'hA1);
    check_span(0, 13, dly(0), dly(0), "R1 R2 R3 R6 basic");
  endtask

  // R2 R4: 48 bclk per frame, full 24-bit words
  task automatic t_wide();
    do_reset(5'd5, 24);
    run_frames(40, 8'h5C);
    check_span(0, 39, dly(5), dly(5), "R2 R4 wide");
  endtask

  // R5: 32 bclk per frame, low 8 bits never sent
  task automatic t_short();
    do_reset(5'd1, 16);
    run_frames(30, 8'hE7);
    check_span(0, 29, dly(1), dly(1), "R5 short slot");
  endtask

  // R7: change in frame 10 to s=2, new delay from frame 12 after mute
  task automatic t_change();
    do_reset(5'd0, 32);
    chg_frame = 10; chg_val = 5'd2;
    run_frames(40, 8'h3D);
    check_span(0, 11, dly(0), dly(0), "R7 before change");
    check_span(12, 39, dly(2), 12 + dly(2), "R7 after change");
  endtask

  // R8: select pulse of 4 bclk is ignored
  task automatic t_glitch();
    do_reset(5'd1, 32);
    chg_frame = 10; chg_val = 5'd3; restore_val = 5'd1; glitch = 1;
    run_frames(30, 8'h96);
    check_span(0, 29, dly(1), dly(1), "R8 glitch ignored");
  endtask

  // R10: largest delay over several pointer wraps
  task automatic t_wrap();
    do_reset(5'd31, 16);
    run_frames(300, 8'h4B);
    check_span(0, 299, dly(31), dly(31), "R10 R2 wrap");
  endtask

  initial begin
    #(20.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 24'h1, 24'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_basic();
    t_wide();
    t_short();
    t_change();
    t_glitch();
    t_wrap();
    chk(pad_bad == 0, "R4 pad bits zero", 24'(pad_bad), 24'h0);
    chk(r9_bad == 0, "R9 falling-edge launch", 24'(r9_bad), 24'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule